// File: doc/BRIEF.md
# Banked Host Register Interface with Sample-Strobe Commit

This block is the host-facing register file of a filter engine. A host processor reaches it over a static-RAM-style port: an 8-bit data bus, a 4-bit register address, and active-low chip-select, read and write strobes. Bit 0 of a configuration register picks one of two banks of sixteen registers. That register is present in both banks. Its other bits carry the operating mode and the filter options.

Filter inputs, gain, leakage and configuration are written into a host-side buffer. The whole buffer is copied to the working copies that feed the filter core at the rising edge of the sample-rate strobe `start_i`. Writing the tap-count register raises a one-cycle core reset. The block also sequences indirect access to the coefficient and sample memories. It keeps a memory pointer that advances once per sample, queues a memory write for the next sample strobe, and returns read data through a two-stage pipeline clocked by the sample strobe.

Top module: `hostreg_bank_if`

## Requirements
- R1: `data_oe_o` is 1 exactly while `cs_ni` and `rd_ni` are both 0. While it is 0, `data_o` is 0x00.
- R2: The configuration register is written at address 0xF in either bank and is read at 0xF or 0xE in either bank. Its bit 0 selects the bank (1 = bank 1) and takes effect for the next access. The other bits are: bit 1 leakage enable, bit 2 dc tap, bit 3 adaptation off, bit 4 output rounding, bit 5 not first in chain, bit 6 dual filter, bit 7 adaptive.
- R3: Bank 0 reads return these values:
  - addresses 0..3: `out_word_i` bytes 3, 2, 1, 0;
  - addresses 4/5: `last1_i` high/low;
  - addresses 6/7: `last2_i` high/low;
  - addresses 8/9: the sample-memory read holding register, high/low;
  - addresses 0xA/0xB/0xC: the coefficient read holding register, high/mid/low.
- R4: Bank 0 writes fill a host buffer. Addresses 0/1 hold input 1 (high/low), 2/3 the reference, 4/5 the gain and 6/7 input 2. Bank 1 address 0 holds leakage. The buffer and the configuration byte reach `x1_o`, `d_o`, `k_o`, `x2_o`, `leak_o` and `cfg_o` only at a rising edge of `start_i`.
- R5: A write to bank 1 address 1 loads `taps_o` at once and pulses `core_rst_o` for exactly one cycle. After reset `taps_o` is 0xFF.
- R6: Unused slots (bank 0 address 0xD on read, bank 1 addresses 2..0xD) read 0x00. Writes to unused slots change nothing.
- R7: Bank 0 address 0xD loads the memory pointer `mem_addr_o`. The pointer advances by one at every rising edge of `start_i`.
- R8: A write to address 9 (sample low byte, with address 8 as the high byte) queues a sample-memory write. A write to address 0xC (coefficient low byte, with 0xA/0xB as high/mid) queues a coefficient write. At the next `start_i` rising edge the queued value is written at the pointer value held before that edge advances it.
- R9: After the pointer is loaded with A, the value stored at A can be read through addresses 8..0xC once two `start_i` rising edges have passed.
- R10: A write whose capture falls while `start_i` is 1 is discarded and sets `wr_err_o`, which stays set until reset.
- R11: Strobes pass through two-flop synchronizers. A write is taken on the rising edge of the synchronized `wr_ni` and only while the synchronized `cs_ni` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 4 | Register address |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Bus drive enable |
| start_i | input | 1 | Sample-rate strobe, synchronous |
| out_word_i | input | 32 | Filter result from core |
| last1_i | input | 16 | Last tap of channel 1 |
| last2_i | input | 16 | Last tap of channel 2 |
| cfg_o | output | 8 | Working configuration |
| x1_o | output | 16 | Working input 1 |
| x2_o | output | 16 | Working input 2 |
| d_o | output | 16 | Working reference |
| k_o | output | 16 | Working gain |
| leak_o | output | 8 | Working leakage |
| taps_o | output | 8 | Tap count minus one |
| core_rst_o | output | 1 | One-cycle core timing reset |
| mem_addr_o | output | 8 | Memory pointer |
| coef_we_o | output | 1 | Coefficient memory write enable |
| coef_wdata_o | output | 24 | Coefficient write data |
| coef_rdata_i | input | 24 | Coefficient read data at pointer |
| data_we_o | output | 1 | Sample memory write enable |
| data_wdata_o | output | 16 | Sample write data |
| data_rdata_i | input | 16 | Sample read data at pointer |
| wr_err_o | output | 1 | Sticky dropped-write flag |

## Verification
The bench checks that working outputs stay frozen until a sample strobe arrives; a design that forwarded the host buffer straight through would show new values early. It writes the configuration byte from inside bank 1 and reads unused bank 1 slots, so a design that decoded the shared register per bank would get stranded in bank 1 or return stale bytes. For memory access it checks the write landing at the pointer value before the increment, and read data appearing only after the second strobe; an off-by-one pipeline returns the wrong word. A write held low across a strobe, a strobe without chip select, and a write captured during a high `start_i` must each leave the working copies untouched. The last of these must also raise the error flag.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 4;
  localparam int SMP_W  = 16;
  localparam int COEF_W = 24;
  localparam int MEM_AW = 8;

  typedef struct packed {
    logic adaptive;
    logic dual;
    logic not_first;
    logic round_en;
    logic adapt_off;
    logic dc_tap;
    logic leak_en;
    logic bank;
  } cfg_t;

  // shared slots
  localparam logic [ADDR_W-1:0] A_CFG     = 4'hF;
  localparam logic [ADDR_W-1:0] A_CFG_ALT = 4'hE;
  // bank 1
  localparam logic [ADDR_W-1:0] A_LEAK    = 4'h0;
  localparam logic [ADDR_W-1:0] A_TAPS    = 4'h1;
  // bank 0 indirect memory access
  localparam logic [ADDR_W-1:0] A_DM_HI   = 4'h8;
  localparam logic [ADDR_W-1:0] A_DM_LO   = 4'h9;
  localparam logic [ADDR_W-1:0] A_CM_HI   = 4'hA;
  localparam logic [ADDR_W-1:0] A_CM_MID  = 4'hB;
  localparam logic [ADDR_W-1:0] A_CM_LO   = 4'hC;
  localparam logic [ADDR_W-1:0] A_PTR     = 4'hD;
endpackage

// File: rtl/hostreg_sync.sv
module hostreg_sync #(
  parameter int           N       = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sync_o = s2_q;
  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/hostreg_file.sv
module hostreg_file
  import hostreg_pkg::*;
#(
  parameter int               BW      = hostreg_pkg::BUS_W,
  parameter int               AW      = hostreg_pkg::ADDR_W,
  parameter int               SW      = hostreg_pkg::SMP_W,
  parameter logic [BW-1:0]    TAP_RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          start_pulse_i,
  output logic [BW-1:0] cfg_host_o,
  output logic [BW-1:0] cfg_o,
  output logic [SW-1:0] x1_o,
  output logic [SW-1:0] d_o,
  output logic [SW-1:0] k_o,
  output logic [SW-1:0] x2_o,
  output logic [BW-1:0] leak_o,
  output logic [BW-1:0] taps_o,
  output logic          core_rst_o
);
  localparam int NWORD = 4;
  localparam int WSEL  = $clog2(NWORD);

  logic [SW-1:0] sh_q [NWORD];
  logic [SW-1:0] wk_q [NWORD];
  cfg_t          cfg_sh_q, cfg_wk_q;
  logic [BW-1:0] leak_sh_q, leak_wk_q, taps_q;
  logic          core_rst_q;
  logic          b0_w, b1_w;

  assign b0_w = wr_en_i && !cfg_sh_q.bank;
  assign b1_w = wr_en_i &&  cfg_sh_q.bank;

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q[g] <= '0;
        wk_q[g] <= '0;
      end else begin
        if (b0_w && !addr_i[AW-1] && addr_i[WSEL:1] == WSEL'(g)) begin
          if (!addr_i[0]) sh_q[g][SW-1 -: BW] <= wdata_i;
          else            sh_q[g][BW-1:0]     <= wdata_i;
        end
        if (start_pulse_i) wk_q[g] <= sh_q[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_sh_q   <= '0;
      cfg_wk_q   <= '0;
      leak_sh_q  <= '0;
      leak_wk_q  <= '0;
      taps_q     <= TAP_RST;
      core_rst_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_CFG) cfg_sh_q  <= cfg_t'(wdata_i);
      if (b1_w && addr_i == A_LEAK)   leak_sh_q <= wdata_i;
      core_rst_q <= b1_w && addr_i == A_TAPS;
      if (b1_w && addr_i == A_TAPS)   taps_q    <= wdata_i;
      if (start_pulse_i) begin
        cfg_wk_q  <= cfg_sh_q;
        leak_wk_q <= leak_sh_q;
      end
    end
  end

  assign cfg_host_o = cfg_sh_q;
  assign cfg_o      = cfg_wk_q;
  assign x1_o       = wk_q[0];
  assign d_o        = wk_q[1];
  assign k_o        = wk_q[2];
  assign x2_o       = wk_q[3];
  assign leak_o     = leak_wk_q;
  assign taps_o     = taps_q;
  assign core_rst_o = core_rst_q;

  AST_WORK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_pulse_i |=> $stable(cfg_o) && $stable(leak_o) && $stable(x1_o)
                       && $stable(x2_o) && $stable(d_o) && $stable(k_o));  // R4
  AST_TAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b1_w && addr_i == A_TAPS) |=> core_rst_o && taps_o == $past(wdata_i));  // R5
endmodule

// File: rtl/hostreg_ram.sv
module hostreg_ram
  import hostreg_pkg::*;
#(
  parameter int BW  = hostreg_pkg::BUS_W,
  parameter int AW  = hostreg_pkg::ADDR_W,
  parameter int SW  = hostreg_pkg::SMP_W,
  parameter int CW  = hostreg_pkg::COEF_W,
  parameter int MAW = hostreg_pkg::MEM_AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic           bank_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [BW-1:0]  wdata_i,
  input  logic           start_pulse_i,
  output logic [MAW-1:0] mem_addr_o,
  output logic           coef_we_o,
  output logic [CW-1:0]  coef_wdata_o,
  input  logic [CW-1:0]  coef_rdata_i,
  output logic           data_we_o,
  output logic [SW-1:0]  data_wdata_o,
  input  logic [SW-1:0]  data_rdata_i,
  output logic [SW-1:0]  dhold_o,
  output logic [CW-1:0]  chold_o
);
  logic [MAW-1:0] ptr_q;
  logic [SW-1:0]  dwr_q, dstage_q, dhold_q;
  logic [CW-1:0]  cwr_q, cstage_q, chold_q;
  logic           d_pend_q, c_pend_q;
  logic           b0_w, ptr_w;

  assign b0_w  = wr_en_i && !bank_i;
  assign ptr_w = b0_w && addr_i == A_PTR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      dwr_q    <= '0;
      cwr_q    <= '0;
      d_pend_q <= 1'b0;
      c_pend_q <= 1'b0;
      dstage_q <= '0;
      dhold_q  <= '0;
      cstage_q <= '0;
      chold_q  <= '0;
    end else begin
      if (ptr_w)              ptr_q <= MAW'(wdata_i);
      else if (start_pulse_i) ptr_q <= ptr_q + 1'b1;
      if (b0_w) begin
        case (addr_i)
          A_DM_HI:  dwr_q[SW-1 -: BW] <= wdata_i;
          A_DM_LO:  begin dwr_q[BW-1:0] <= wdata_i; d_pend_q <= 1'b1; end
          A_CM_HI:  cwr_q[CW-1 -: BW] <= wdata_i;
          A_CM_MID: cwr_q[CW-BW-1 -: BW] <= wdata_i;
          A_CM_LO:  begin cwr_q[BW-1:0] <= wdata_i; c_pend_q <= 1'b1; end
          default: ;
        endcase
      end
      if (start_pulse_i) begin
        d_pend_q <= 1'b0;
        c_pend_q <= 1'b0;
        // two sample periods from pointer load to host-visible data
        dstage_q <= data_rdata_i;
        dhold_q  <= dstage_q;
        cstage_q <= coef_rdata_i;
        chold_q  <= cstage_q;
      end
    end
  end

  assign mem_addr_o   = ptr_q;
  assign data_we_o    = start_pulse_i && d_pend_q;
  assign data_wdata_o = dwr_q;
  assign coef_we_o    = start_pulse_i && c_pend_q;
  assign coef_wdata_o = cwr_q;
  assign dhold_o      = dhold_q;
  assign chold_o      = chold_q;

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_pulse_i && !ptr_w) |=> mem_addr_o == MAW'($past(mem_addr_o) + 1'b1));  // R7
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse_i |=> !d_pend_q && !c_pend_q);  // R8
endmodule

// File: rtl/hostreg_bank_if.sv
module hostreg_bank_if
  import hostreg_pkg::*;
#(
  parameter int BW  = hostreg_pkg::BUS_W,
  parameter int AW  = hostreg_pkg::ADDR_W,
  parameter int SW  = hostreg_pkg::SMP_W,
  parameter int CW  = hostreg_pkg::COEF_W,
  parameter int MAW = hostreg_pkg::MEM_AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            rd_ni,
  input  logic            wr_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [BW-1:0]   data_i,
  output logic [BW-1:0]   data_o,
  output logic            data_oe_o,
  input  logic            start_i,
  input  logic [4*BW-1:0] out_word_i,
  input  logic [SW-1:0]   last1_i,
  input  logic [SW-1:0]   last2_i,
  output logic [BW-1:0]   cfg_o,
  output logic [SW-1:0]   x1_o,
  output logic [SW-1:0]   x2_o,
  output logic [SW-1:0]   d_o,
  output logic [SW-1:0]   k_o,
  output logic [BW-1:0]   leak_o,
  output logic [BW-1:0]   taps_o,
  output logic            core_rst_o,
  output logic [MAW-1:0]  mem_addr_o,
  output logic            coef_we_o,
  output logic [CW-1:0]   coef_wdata_o,
  input  logic [CW-1:0]   coef_rdata_i,
  output logic            data_we_o,
  output logic [SW-1:0]   data_wdata_o,
  input  logic [SW-1:0]   data_rdata_i,
  output logic            wr_err_o
);
  logic [1:0]    stb_sync, stb_rise;
  logic          start_q, start_pulse;
  logic          wr_evt, wr_en, err_q;
  logic [BW-1:0] cfg_host, rd_byte;
  logic [SW-1:0] dhold;
  logic [CW-1:0] chold;

  hostreg_sync #(.N(2), .RST_VAL(2'b11)) u_sync (
    .clk_i, .rst_ni, .async_i({cs_ni, wr_ni}), .sync_o(stb_sync), .rise_o(stb_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= start_i;
      if (wr_evt && start_i) err_q <= 1'b1;
    end
  end

  assign start_pulse = start_i && !start_q;
  assign wr_evt      = stb_rise[0] && !stb_sync[1];
  assign wr_en       = wr_evt && !start_i;
  assign wr_err_o    = err_q;

  hostreg_file #(.BW(BW), .AW(AW), .SW(SW)) u_file (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i, .wdata_i(data_i),
    .start_pulse_i(start_pulse), .cfg_host_o(cfg_host), .cfg_o,
    .x1_o, .d_o, .k_o, .x2_o, .leak_o, .taps_o, .core_rst_o
  );

  hostreg_ram #(.BW(BW), .AW(AW), .SW(SW), .CW(CW), .MAW(MAW)) u_ram (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .bank_i(cfg_host[0]), .addr_i,
    .wdata_i(data_i), .start_pulse_i(start_pulse), .mem_addr_o,
    .coef_we_o, .coef_wdata_o, .coef_rdata_i, .data_we_o, .data_wdata_o,
    .data_rdata_i, .dhold_o(dhold), .chold_o(chold)
  );

  always_comb begin
    rd_byte = '0;
    if (addr_i == A_CFG || addr_i == A_CFG_ALT) begin
      rd_byte = cfg_host;
    end else if (!cfg_host[0]) begin
      case (addr_i)
        AW'(0):   rd_byte = out_word_i[4*BW-1 -: BW];
        AW'(1):   rd_byte = out_word_i[3*BW-1 -: BW];
        AW'(2):   rd_byte = out_word_i[2*BW-1 -: BW];
        AW'(3):   rd_byte = out_word_i[BW-1:0];
        AW'(4):   rd_byte = last1_i[SW-1 -: BW];
        AW'(5):   rd_byte = last1_i[BW-1:0];
        AW'(6):   rd_byte = last2_i[SW-1 -: BW];
        AW'(7):   rd_byte = last2_i[BW-1:0];
        A_DM_HI:  rd_byte = dhold[SW-1 -: BW];
        A_DM_LO:  rd_byte = dhold[BW-1:0];
        A_CM_HI:  rd_byte = chold[CW-1 -: BW];
        A_CM_MID: rd_byte = chold[CW-BW-1 -: BW];
        A_CM_LO:  rd_byte = chold[BW-1:0];
        default:  rd_byte = '0;
      endcase
    end
  end

  assign data_oe_o = !cs_ni && !rd_ni;
  assign data_o    = data_oe_o ? rd_byte : '0;

  AST_DROP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && start_i) |=> wr_err_o);  // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> wr_err_o);  // R10
endmodule

// File: tb/hostreg_bank_if_test.sv
module hostreg_bank_if_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [3:0]  addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe_o;
  logic        start_i = 1'b0;
  logic [31:0] out_word_i = 32'hA1B2C3D4;
  logic [15:0] last1_i = 16'h5566, last2_i = 16'h7788;
  logic [7:0]  cfg_o, leak_o, taps_o, mem_addr_o;
  logic [15:0] x1_o, x2_o, d_o, k_o, data_wdata_o, data_rdata_i;
  logic [23:0] coef_wdata_o, coef_rdata_i;
  logic        core_rst_o, coef_we_o, data_we_o, wr_err_o;

  logic [15:0] dmem [256];
  logic [23:0] cmem [256];
  logic        pl_we = 1'b0;
  logic [7:0]  pl_a = '0;
  logic [15:0] pl_d16 = '0;
  logic [23:0] pl_d24 = '0;

  int checks = 0, fails = 0, rst_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hostreg_bank_if uut (
    .clk_i(clk), .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i, .data_o,
    .data_oe_o, .start_i, .out_word_i, .last1_i, .last2_i, .cfg_o, .x1_o,
    .x2_o, .d_o, .k_o, .leak_o, .taps_o, .core_rst_o, .mem_addr_o, .coef_we_o,
    .coef_wdata_o, .coef_rdata_i, .data_we_o, .data_wdata_o, .data_rdata_i,
    .wr_err_o
  );

  always @(posedge clk) begin
    if (data_we_o) dmem[mem_addr_o] <= data_wdata_o;
    if (coef_we_o) cmem[mem_addr_o] <= coef_wdata_o;
    if (pl_we) begin
      dmem[pl_a] <= pl_d16;
      cmem[pl_a] <= pl_d24;
    end
    if (core_rst_o) rst_cnt <= rst_cnt + 1;
  end
  assign data_rdata_i = dmem[mem_addr_o];
  assign coef_rdata_i = cmem[mem_addr_o];

  // {word address of high byte, value}
  localparam int NV = 4;
  localparam logic [19:0] VEC [NV] = '{
    {4'h0, 16'h1234}, {4'h2, 16'hBEEF}, {4'h4, 16'h0155}, {4'h6, 16'h8001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_out(input logic [3:0] a);
    case (a)
      4'h0: return x1_o;
      4'h2: return d_o;
      4'h4: return k_o;
      default: return x2_o;
    endcase
  endfunction

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; data_i = d; cs_ni = 1'b0; wr_ni = 1'b0;
    repeat (3) @(negedge clk);
    wr_ni = 1'b1;
    repeat (5) @(negedge clk);
    cs_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; cs_ni = 1'b0; rd_ni = 1'b0;
    #1 d = data_o;
    @(negedge clk);
    rd_ni = 1'b1; cs_ni = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 reset oe", data_oe_o, 0);
    chk("R4 reset cfg_o", cfg_o, 0);
    chk("R4 reset x1_o", x1_o, 0);
    chk("R5 reset taps_o", taps_o, 8'hFF);
    chk("R10 reset err", wr_err_o, 0);
    chk("R7 reset ptr", mem_addr_o, 0);
    cs_ni = 1'b1; rd_ni = 1'b0; #1;
    chk("R1 no cs no drive", {data_oe_o, data_o}, 0);
    cs_ni = 1'b0; rd_ni = 1'b1; #1;
    chk("R1 no rd no drive", {data_oe_o, data_o}, 0);
    cs_ni = 1'b1;

    // R4 buffered word registers, table driven
    for (int i = 0; i < NV; i++) begin
      host_wr(VEC[i][19:16], VEC[i][15:8]);
      host_wr(VEC[i][19:16] + 4'd1, VEC[i][7:0]);
      chk("R4 held before start", word_out(VEC[i][19:16]), 0);
    end
    pulse_start();
    for (int i = 0; i < NV; i++)
      chk("R4 committed on start", word_out(VEC[i][19:16]), VEC[i][15:0]);

    // R2 configuration
    host_wr(4'hF, 8'h94);
    host_rd(4'hF, rb); chk("R2 cfg read F", rb, 8'h94);
    host_rd(4'hE, rb); chk("R2 cfg read E", rb, 8'h94);
    chk("R4 cfg_o held", cfg_o, 0);
    pulse_start();
    chk("R4 cfg_o committed", cfg_o, 8'h94);

    // bank 1
    host_wr(4'hF, 8'h95);
    host_rd(4'hF, rb); chk("R2 cfg read in bank 1", rb, 8'h95);
    host_wr(4'h0, 8'h3C);
    host_wr(4'h1, 8'h1F);
    chk("R5 taps loaded", taps_o, 8'h1F);
    chk("R5 one reset pulse", rst_cnt, 1);
    host_wr(4'h7, 8'hAA);
    host_rd(4'h7, rb); chk("R6 bank1 unused write", rb, 0);
    host_rd(4'h5, rb); chk("R6 bank1 unused read", rb, 0);
    chk("R4 leak held", leak_o, 0);
    pulse_start();
    chk("R4 leak committed", leak_o, 8'h3C);
    chk("R6 x1 untouched by bank1", x1_o, 16'h1234);
    host_wr(4'hF, 8'h94);

    // R3 read map
    host_rd(4'h0, rb); chk("R3 out byte3", rb, 8'hA1);
    host_rd(4'h1, rb); chk("R3 out byte2", rb, 8'hB2);
    host_rd(4'h2, rb); chk("R3 out byte1", rb, 8'hC3);
    host_rd(4'h3, rb); chk("R3 out byte0", rb, 8'hD4);
    host_rd(4'h4, rb); chk("R3 last1 hi", rb, 8'h55);
    host_rd(4'h5, rb); chk("R3 last1 lo", rb, 8'h66);
    host_rd(4'h6, rb); chk("R3 last2 hi", rb, 8'h77);
    host_rd(4'h7, rb); chk("R3 last2 lo", rb, 8'h88);
    host_rd(4'hD, rb); chk("R6 bank0 D read", rb, 0);

    // R8 indirect writes, R7 pointer
    host_wr(4'hD, 8'h10);
    chk("R7 pointer loaded", mem_addr_o, 8'h10);
    host_wr(4'h8, 8'h12);
    host_wr(4'h9, 8'h34);
    pulse_start();
    chk("R8 data mem write", dmem[8'h10], 16'h1234);
    chk("R7 pointer advanced", mem_addr_o, 8'h11);
    host_wr(4'hA, 8'hAB);
    host_wr(4'hB, 8'hCD);
    host_wr(4'hC, 8'hEF);
    pulse_start();
    chk("R8 coef mem write", cmem[8'h11], 24'hABCDEF);
    chk("R7 pointer advanced again", mem_addr_o, 8'h12);

    // R9 indirect read
    @(negedge clk);
    pl_a = 8'h40; pl_d16 = 16'h5A6B; pl_d24 = 24'h010203; pl_we = 1'b1;
    @(negedge clk); pl_we = 1'b0;
    host_wr(4'hD, 8'h40);
    pulse_start();
    pulse_start();
    host_rd(4'h8, rb); chk("R9 data hi", rb, 8'h5A);
    host_rd(4'h9, rb); chk("R9 data lo", rb, 8'h6B);
    host_rd(4'hA, rb); chk("R9 coef hi", rb, 8'h01);
    host_rd(4'hB, rb); chk("R9 coef mid", rb, 8'h02);
    host_rd(4'hC, rb); chk("R9 coef lo", rb, 8'h03);
    chk("R7 two steps", mem_addr_o, 8'h42);

    // R10 write during start
    @(negedge clk); start_i = 1'b1;
    host_wr(4'h0, 8'h77);
    @(negedge clk); start_i = 1'b0;
    chk("R10 error flag", wr_err_o, 1);
    pulse_start();
    chk("R10 dropped write", x1_o, 16'h1234);
    chk("R10 flag sticky", wr_err_o, 1);

    // R11 strobe without chip select
    @(negedge clk);
    addr_i = 4'h0; data_i = 8'h99; wr_ni = 1'b0;
    repeat (3) @(negedge clk);
    wr_ni = 1'b1;
    repeat (5) @(negedge clk);
    pulse_start();
    chk("R11 no cs no write", x1_o, 16'h1234);

    // R11 capture on rising edge only
    @(negedge clk);
    addr_i = 4'h1; data_i = 8'h56; cs_ni = 1'b0; wr_ni = 1'b0;
    repeat (6) @(negedge clk);
    pulse_start();
    chk("R11 held low not taken", x1_o, 16'h1234);
    wr_ni = 1'b1;
    repeat (5) @(negedge clk);
    cs_ni = 1'b1;
    pulse_start();
    chk("R11 taken on rise", x1_o, 16'h1256);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule